// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a small processor interface that has an 8-bit data path. The low address byte and the data share one set of pins. The remaining upper address bits come out on their own address-only pins. A request is accepted only while the sequencer is idle. Each accepted request becomes a four-phase bus cycle, T1 to T4. In T1 an address latch strobe marks the address. Data moves in the later phases. Wait states are added in T3 until a ready condition is seen. That condition is the OR of a synchronous ready input and an asynchronous ready input; the asynchronous one first passes through a flop synchronizer. When the cycle ends, a one-cycle done pulse is issued. For reads, the data sampled from the shared pins is returned with it.

The sequencer can hand the bus to another master. A hold request is granted only between cycles, and while it is granted every address and data driver is released. A request can ask for the address phase to be suppressed. In that case no address is driven at all, and the shared pins in T1 carry write data or nothing. While reset is held, the shared pins are sampled every clock into a configuration word. That word keeps its value after reset is released.

Top module: `mux_bus_seq`

## Requirements
- R1: On a cycle with the address phase enabled, the shared pins drive the low address byte (address bits DATA_W-1:0) in T1. On a write they drive the write data in T2, T3 and T4. On a read they are released (ad_oe low) in T2, T3 and T4.
- R2: With the address phase enabled, ao_oe is high from T1 through T4 and ao_out carries address bits ADDR_W-1:DATA_W, unchanged over the whole cycle.
- R3: ale is high exactly during T1, one clock per cycle. It falls while the address-only pins still hold the same address.
- R4: hold_ack rises only from the idle state. When hold_req and req_valid are both seen in idle, the hold wins. A hold_req that arrives during a cycle is granted one clock after that cycle's done pulse. While hold_ack is high, ad_oe and ao_oe are low and ale is driven low. Dropping hold_req returns the block to idle on the next clock.
- R5: The combined ready is the synchronized ardy_async ORed with srdy. T3 repeats until this combined ready is high at a clock edge, and then T4 follows. With srdy kept low for w T3 clocks and ardy_async low, done rises 4+w clocks after the T1 clock.
- R6: ardy_async passes through SYNC_STAGES flops before it is used. If it rises during the first T3 clock while srdy is low, exactly SYNC_STAGES wait clocks are added. If it is held high, no wait clocks are added.
- R7: done is a one-clock pulse in the clock after T4. For a read, rd_data holds the ad_in value sampled at the end of T4.
- R8: When req_noaddr is set, ao_oe stays low for the whole cycle. In T1 of a read the shared pins are released. In T1 of a write they drive the write data, with wlb_n low.
- R9: While rst_n is low, ad_oe, ao_oe and ale are low, and cfg_word takes the ad_in value on every clock. After reset is released, cfg_word no longer follows ad_in.
- R10: rd_n is low during T2 and every T3 clock of a read. wlb_n is low during T2 and every T3 clock of a write. Both are high in T4 and in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request, taken in idle |
| req_addr | input | ADDR_W | Cycle address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_noaddr | input | 1 | Suppress the address phase |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | DATA_W | Read data captured in T4 |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Hold granted, drivers released |
| ardy_async | input | 1 | Asynchronous ready, active high |
| srdy | input | 1 | Synchronous ready, active high |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wlb_n | output | 1 | Write low-byte strobe, active low |
| ad_in | input | DATA_W | Shared pins, input side |
| ad_out | output | DATA_W | Shared pins, output side |
| ad_oe | output | 1 | Shared pin driver enable |
| ao_out | output | ADDR_W-DATA_W | Address-only pins |
| ao_oe | output | 1 | Address-only pin driver enable |
| cfg_word | output | DATA_W | Configuration captured during reset |

## Verification
The assertions assume four things about the inputs. Requests arrive only while busy is low. The request fields are steady for the clock in which they are taken. hold_req stays high until hold_ack has been seen. ardy_async is allowed to change at any edge, because it is synchronized inside the block. The bench drives every input at the falling clock edge and raises req_valid only when idle, for exactly one clock. It also leaves ardy_async low long enough that the synchronizer is empty before each srdy-only cycle begins.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4,
        PH_HOLD = 3'd5
    } phase_e;
endpackage

// File: rtl/mux_bus_rdy_sync.sv
module mux_bus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/mux_bus_cfg_cap.sv
module mux_bus_cfg_cap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] cfg
);
    logic [W-1:0] cfg_d, cfg_q;

    always_comb cfg_d = rst_n ? cfg_q : bus_in;

    always_ff @(posedge clk) cfg_q <= cfg_d;

    assign cfg = cfg_q;
endmodule

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
    import mux_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_wr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_noaddr,
    input  logic                     hold_req,
    input  logic                     rdy,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     hold_ack,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wlb_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ao_out,
    output logic                     ao_oe
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        phase_e              ph;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                wr;
        logic                noaddr;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (hold_req) begin
                    d.ph = PH_HOLD;
                end else if (req_valid) begin
                    d.ph     = PH_T1;
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                    d.wr     = req_wr;
                    d.noaddr = req_noaddr;
                end
            end
            PH_T1:   d.ph = PH_T2;
            PH_T2:   d.ph = PH_T3;
            PH_T3:   if (rdy) d.ph = PH_T4;
            PH_T4: begin
                d.ph   = PH_IDLE;
                d.done = 1'b1;
                if (!q.wr) d.rdata = ad_in;
            end
            PH_HOLD: if (!hold_req) d.ph = PH_IDLE;
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic in_t1, in_mid, in_cyc;
    always_comb begin
        in_t1  = (q.ph == PH_T1);
        in_mid = (q.ph == PH_T2) || (q.ph == PH_T3);
        in_cyc = in_t1 || in_mid || (q.ph == PH_T4);
    end

    assign busy     = (q.ph != PH_IDLE);
    assign done     = q.done;
    assign rd_data  = q.rdata;
    assign hold_ack = (q.ph == PH_HOLD);
    assign ale      = in_t1;
    assign ao_oe    = in_cyc && !q.noaddr;
    assign ao_out   = q.addr[ADDR_W-1:DATA_W];
    assign ad_oe    = (in_t1 && (!q.noaddr || q.wr)) || ((in_mid || q.ph == PH_T4) && q.wr);
    assign ad_out   = (in_t1 && !q.noaddr) ? q.addr[DATA_W-1:0] : q.wdata;
    assign rd_n     = !(in_mid && !q.wr);
    assign wlb_n    = !((in_mid || (in_t1 && q.noaddr)) && q.wr);

    a_r2_ao_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ao_oe && !ale) |-> (ao_out == $past(ao_out)));
    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    a_r3_ale_fall_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> $stable(ao_out));
    a_r4_hold_float: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ad_oe && !ao_oe && !ale));
    a_r4_hold_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> ($past(q.ph) == PH_IDLE));
    a_r5_wait_t3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_T3 && !rdy) |=> (q.ph == PH_T3));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wlb_n));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_wr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_noaddr,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     hold_req,
    output logic                     hold_ack,
    input  logic                     ardy_async,
    input  logic                     srdy,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wlb_n,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ao_out,
    output logic                     ao_oe,
    output logic [DATA_W-1:0]        cfg_word
);
    logic ardy_sync, rdy;

    mux_bus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ardy_async), .sync_out(ardy_sync)
    );

    assign rdy = ardy_sync | srdy;

    mux_bus_cfg_cap #(.W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_in(ad_in), .cfg(cfg_word)
    );

    mux_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_wr(req_wr),
        .req_wdata(req_wdata), .req_noaddr(req_noaddr),
        .hold_req(hold_req), .rdy(rdy), .ad_in(ad_in),
        .busy(busy), .done(done), .rd_data(rd_data), .hold_ack(hold_ack),
        .ale(ale), .rd_n(rd_n), .wlb_n(wlb_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ao_out(ao_out), .ao_oe(ao_oe)
    );

    a_r9_reset_float: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (!ad_oe && !ao_oe && !ale)));
endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_wr = 0, req_noaddr = 0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, ad_in = '0;
    logic hold_req = 0, ardy_async = 0, srdy = 0;
    logic busy, done, hold_ack, ale, rd_n, wlb_n, ad_oe, ao_oe;
    logic [7:0] rd_data, ad_out, ao_out, cfg_word;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_seq u_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wr(req_wr), .req_wdata(req_wdata), .req_noaddr(req_noaddr),
        .busy(busy), .done(done), .rd_data(rd_data), .hold_req(hold_req),
        .hold_ack(hold_ack), .ardy_async(ardy_async), .srdy(srdy), .ale(ale),
        .rd_n(rd_n), .wlb_n(wlb_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .ao_out(ao_out), .ao_oe(ao_oe), .cfg_word(cfg_word)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // mode 0: srdy after w waits; 1: ardy pulse in first T3; 2: ardy held high
    task automatic run_cycle(input logic [15:0] a, input logic w, input logic [7:0] wd,
                             input logic nd, input int waits, input int mode,
                             input logic [7:0] rv);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_wr = w; req_wdata = wd; req_noaddr = nd;
        @(negedge clk);                     // T1
        req_valid = 0;
        chk("R3 ale T1", ale, 1);
        chk("R1/R8 ad_oe T1", ad_oe, (!nd || w));
        if (!nd || w) chk("R1/R8 ad_out T1", ad_out, nd ? wd : a[7:0]);
        chk("R2/R8 ao_oe T1", ao_oe, !nd);
        if (!nd) chk("R2 ao_out T1", ao_out, a[15:8]);
        if (nd) chk("R8 wlb_n T1", wlb_n, !w);
        @(negedge clk);                     // T2
        chk("R3 ale T2", ale, 0);
        if (!nd) chk("R3 ao after ale", ao_out, a[15:8]);
        chk("R1 ad_oe T2", ad_oe, w);
        if (w) chk("R1 ad_out T2", ad_out, wd);
        chk("R10 rd_n T2", rd_n, w);
        chk("R10 wlb_n T2", wlb_n, !w);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);                 // T3 clocks
            chk("R5 no done in T3", done, 0);
            chk("R10 strobe T3", {rd_n, wlb_n}, w ? 2'b10 : 2'b01);
            if (!nd) chk("R2 ao_oe T3", ao_oe, 1);
            if (mode == 0) srdy = (i == waits);
            if (mode == 1 && i == 0) ardy_async = 1;
        end
        @(negedge clk);                     // T4
        srdy = 0;
        if (mode == 1) ardy_async = 0;
        chk("R10 strobes T4", {rd_n, wlb_n}, 2'b11);
        chk("R1 ad_oe T4", ad_oe, w);
        if (!nd) chk("R2 ao_out T4", ao_out, a[15:8]);
        chk("R5/R6 no done T4", done, 0);
        ad_in = rv;
        @(negedge clk);                     // done clock
        chk("R5/R6/R7 done", done, 1);
        if (!w) chk("R7 rd_data", rd_data, rv);
        chk("R7 idle", busy, 0);
        @(negedge clk);
        chk("R7 done pulse", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] addrs [4];
        addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'h12C3; addrs[3] = 16'hA55A;
        // R9: reset float and configuration capture
        ad_in = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R9 ad_oe reset", ad_oe, 0);
        chk("R9 ao_oe reset", ao_oe, 0);
        chk("R9 ale reset", ale, 0);
        chk("R9 cfg capture", cfg_word, 8'h5A);
        ad_in = 8'hC3;
        @(negedge clk);
        chk("R9 cfg follows in reset", cfg_word, 8'hC3);
        rst_n = 1;
        ad_in = 8'h11;
        repeat (2) @(negedge clk);
        chk("R9 cfg held", cfg_word, 8'hC3);
        chk("R9 idle after reset", busy, 0);

        // R1 R2 R3 R5 R7 R8 R10 sweep
        for (int ai = 0; ai < 4; ai++)
            for (int w = 0; w < 2; w++)
                for (int nd = 0; nd < 2; nd++)
                    for (int wt = 0; wt < 4; wt++)
                        run_cycle(addrs[ai], w[0], addrs[ai][7:0] ^ 8'h3C ^ 8'(wt),
                                  nd[0], wt, 0, addrs[ai][15:8] + 8'(wt));

        // R6: async ready pulse gives SYNC_STAGES waits; held high gives none
        run_cycle(16'h4321, 0, 8'h00, 0, 2, 1, 8'h9E);
        run_cycle(16'h8765, 1, 8'h77, 0, 2, 1, 8'h00);
        ardy_async = 1;
        repeat (3) @(negedge clk);
        run_cycle(16'hBEEF, 0, 8'h00, 0, 0, 2, 8'h42);
        run_cycle(16'hCAFE, 1, 8'h5C, 1, 0, 2, 8'h00);
        ardy_async = 0;
        repeat (3) @(negedge clk);

        // R4: hold wins over request in idle
        hold_req = 1; req_valid = 1; req_addr = 16'h1111;
        @(negedge clk);
        chk("R4 hold ack", hold_ack, 1);
        for (int k = 0; k < 3; k++) begin
            chk("R4 ad float", ad_oe, 0);
            chk("R4 ao float", ao_oe, 0);
            chk("R4 ale low", ale, 0);
            @(negedge clk);
        end
        hold_req = 0; req_valid = 0;
        @(negedge clk);
        chk("R4 release", {hold_ack, busy}, 2'b00);

        // R4: hold during a cycle waits for its end
        req_valid = 1; req_addr = 16'h2468; req_wr = 0; req_noaddr = 0;
        @(negedge clk);
        req_valid = 0; hold_req = 1; srdy = 1;
        chk("R4 cycle started", ale, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 no ack mid cycle", hold_ack, 0);
        end
        @(negedge clk);
        chk("R4 done before hold", {done, hold_ack}, 2'b10);
        srdy = 0;
        @(negedge clk);
        chk("R4 ack after cycle", hold_ack, 1);
        hold_req = 0;
        @(negedge clk);
        chk("R4 release 2", hold_ack, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule